// File: doc/BRIEF.md
# Bidirectional I/O Port with Two-Phase Input Synchronizer

This block is an eight-pin general-purpose I/O port. Software reaches it through a small register bus. One writable register sets the direction of each pin, and a second writable register holds the output level of each pin. A read-only register returns the synchronized level of every pin. A pin set as an output drives its output bit onto the pad. A pin set as an input tri-states its driver. On an input pin, the output bit enables a pull-up instead of driving a level.

Every pin level passes through a two-stage synchronizer before software can see it. The first stage captures on the falling clock edge, which behaves like a latch that is open while the clock is high. The second stage is a register clocked on the rising edge. An external transition therefore reaches the pin register between half a clock and one and a half clocks after it occurs. For an output pin, the level the synchronizer sees is the pin's own driven value. A value written by software can therefore be read back exactly one clock after the write.

The register map is as follows:
- Address 0: synchronized pin levels (read-only).
- Address 1: direction register.
- Address 2: output/pull-up register.
- Address 3: unmapped.

Reads return data combinationally in the same cycle as the request. Writes take effect at the rising edge that ends the write cycle.

Top module: `gpio_sync_port`

## Requirements
- R1: While reset is asserted, the pin register is 0x00 and both the direction and output registers read 0x00. The port outputs are all 0: no driver enabled, no pull-up, pad output 0x00.
- R2: A write to address 1 loads the direction register, and a write to address 2 loads the output register. Both are readable at those addresses in the next cycle. A read of address 3 returns 0x00. Writes to address 0 or address 3 change no register and no port output.
- R3: `pad_oe` equals the direction register (bit 1 means drive). `pad_out` equals the output register.
- R4: `pad_pullup` bit n is 1 exactly when direction bit n is 0 and output bit n is 1.
- R5: The level fed to the synchronizer is the output register bit for an output pin and `pad_in` for an input pin. When all pins are outputs, address 0 returns the output register whatever `pad_in` is.
- R6: After a write to the output register in cycle W, a read of address 0 in cycle W+1 returns the old level. A read in cycle W+2 returns the newly driven level.
- R7: A change on `pad_in` that occurs while the clock is high is returned by a read of address 0 in the next cycle. A read in the same cycle returns the old value.
- R8: A change on `pad_in` that occurs while the clock is low is still hidden in the next cycle. It is returned by a read two cycles later.
- R9: With direction 0x0F and output 0xC3, `pad_oe` is 0x0F, pins 0 and 1 drive high, pins 2 and 3 drive low, and `pad_pullup` is 0xC0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address (0 pins, 1 direction, 2 output, 3 unmapped) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the request cycle; 0 when no read is requested |
| pad_in | input | 8 | Level seen at each pad |
| pad_out | output | 8 | Level driven on each pad |
| pad_oe | output | 8 | Driver enable per pad |
| pad_pullup | output | 8 | Pull-up enable per pad |

## Verification
The bench builds the port with its default width of eight pins, so the mixed direction pattern from R9 can be applied. That width also lets one pad word hold output pins and input pins at the same time, so a single read of address 0 shows both sources of the synchronizer input. The bench changes the pads at two offsets within a cycle: one before the falling edge and one after it. This brings both ends of the half-to-one-and-a-half-cycle input window within reach. A write followed by reads on the next two cycles pins down the one-cycle readback latency.

// File: rtl/gpio_sync_pkg.sv
`timescale 1ns/1ps
package gpio_sync_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PINS = 2'd0,
    REG_DIR  = 2'd1,
    REG_OUT  = 2'd2,
    REG_NONE = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_ctrl_regs.sv
`timescale 1ns/1ps
module gpio_ctrl_regs
  import gpio_sync_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  out_q
);
  logic             dir_en, out_en;
  logic [WIDTH-1:0] dir_d, out_d;

  // next-state: decode which register takes the write data
  always_comb begin
    dir_en = wr_en && (wr_addr == REG_DIR);
    out_en = wr_en && (wr_addr == REG_OUT);
    dir_d  = wr_data;
    out_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (dir_en) dir_q <= dir_d;
      if (out_en) out_q <= out_d;
    end
  end
endmodule

// File: rtl/gpio_pad_mux.sv
`timescale 1ns/1ps
module gpio_pad_mux #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] out_q,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pullup,
  output logic [WIDTH-1:0] pin_level
);
  for (genvar n = 0; n < WIDTH; n++) begin : g_pin
    always_comb begin
      pad_oe[n]     = dir_q[n];
      pad_out[n]    = out_q[n];
      pad_pullup[n] = !dir_q[n] && out_q[n];
      // an output pin observes its own driven level
      pin_level[n]  = dir_q[n] ? out_q[n] : pad_in[n];
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] pin_q
);
  logic [WIDTH-1:0] hold_q;

  // stage 1: value present when the clock falls (open-while-high latch)
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= level_i;
  end

  // stage 2: pin register on the rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= hold_q;
  end
endmodule

// File: rtl/gpio_sync_port.sv
`timescale 1ns/1ps
module gpio_sync_port
  import gpio_sync_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_pullup
);
  logic [WIDTH-1:0] dir_q, out_q, pin_level, pin_q;
  logic             wr_en, rd_en;

  assign wr_en = bus_sel && bus_we;
  assign rd_en = bus_sel && !bus_we;

  gpio_ctrl_regs #(.WIDTH(WIDTH)) regs_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(bus_addr),
    .wr_data(bus_wdata),
    .dir_q  (dir_q),
    .out_q  (out_q)
  );

  gpio_pad_mux #(.WIDTH(WIDTH)) mux_i (
    .dir_q     (dir_q),
    .out_q     (out_q),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pullup(pad_pullup),
    .pin_level (pin_level)
  );

  gpio_in_sync #(.WIDTH(WIDTH)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .level_i(pin_level),
    .pin_q  (pin_q)
  );

  // combinational read port
  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (bus_addr)
        REG_PINS: bus_rdata = pin_q;
        REG_DIR:  bus_rdata = dir_q;
        REG_OUT:  bus_rdata = out_q;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_sync_port_chk.sv
`timescale 1ns/1ps
module gpio_sync_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_pullup,
  input logic [WIDTH-1:0] pin_q
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (pad_oe == '0 && pad_pullup == '0 && pin_q == '0); // R1
    end
  end

  AST_DIR_WRITE_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 2'd1) |=> (pad_oe == $past(bus_wdata))); // R3

  AST_OUT_WRITE_TO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 2'd2) |=> (pad_out == $past(bus_wdata))); // R3

  AST_PULLUP_ONLY_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pullup & pad_oe) == '0); // R4

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == 2'd3) |-> (bus_rdata == '0)); // R2

  AST_OUT_PIN_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_q & $past(pad_oe)) == ($past(pad_out) & $past(pad_oe))); // R6
endmodule

bind gpio_sync_port gpio_sync_port_chk #(.WIDTH(WIDTH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pad_pullup(pad_pullup),
  .pin_q     (pin_q)
);

// File: tb/gpio_sync_port_tb_top.sv
`timescale 1ns/1ps
module gpio_sync_port_tb_top;
  localparam int CLK_P = 10;
  localparam int W     = 8;

  logic         clk;
  logic         rst_n;
  logic         bus_sel, bus_we;
  logic [1:0]   bus_addr;
  logic [W-1:0] bus_wdata, bus_rdata, pad_in, pad_out, pad_oe, pad_pullup;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  gpio_sync_port #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pullup(pad_pullup)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver tasks: drive 1 ns after the rising edge
  task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [W-1:0] exp, input string tag);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wdata = '0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic bus_idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_we = 1'b0;
    end
  endtask

  // called right after bus_idle: samples pads late in the same cycle
  task automatic pad_check(input string tag, input logic [W-1:0] oe,
                           input logic [W-1:0] po, input logic [W-1:0] pu);
    #7;
    check({tag, " pad_oe"}, pad_oe, oe);
    check({tag, " pad_out"}, pad_out, po);
    check({tag, " pad_pullup"}, pad_pullup, pu);
  endtask

  // monitor: compares read data late in each cycle against the scoreboard
  initial begin
    forever begin
      @(posedge clk); #8;
      if (bus_sel && !bus_we) begin
        if (exp_q.size() == 0) begin
          check("scoreboard underflow", bus_rdata, 'x);
        end else begin
          check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = 8'h5A;
    bus_idle(2);
    pad_check("R1 reset pads", 8'h00, 8'h00, 8'h00);
    bus_read(2'd0, 8'h00, "R1 pins in reset");
    bus_read(2'd1, 8'h00, "R1 dir in reset");
    bus_read(2'd2, 8'h00, "R1 out in reset");
    @(posedge clk); #1; rst_n = 1'b1; bus_sel = 1'b0;
    bus_idle(2);
    bus_read(2'd0, 8'h5A, "R5 input pins follow pad");
    // R9 direction/output pattern
    bus_write(2'd1, 8'h0F);
    bus_write(2'd2, 8'hC3);
    bus_read(2'd1, 8'h0F, "R2 dir readback");
    bus_read(2'd2, 8'hC3, "R2 out readback");
    bus_idle(1);
    pad_check("R9 R3 R4 mixed pattern", 8'h0F, 8'hC3, 8'hC0);
    bus_idle(1);
    bus_read(2'd0, 8'h53, "R5 R9 mixed pin levels");
    // R6 readback latency of a written output
    bus_write(2'd2, 8'hCC);
    bus_read(2'd0, 8'h53, "R6 next cycle old value");
    bus_read(2'd0, 8'h5C, "R6 second cycle new value");
    // R7 pad change while clock high
    bus_read(2'd0, 8'h5C, "R7 same cycle old value");
    #1 pad_in = 8'hA5;
    bus_read(2'd0, 8'hAC, "R7 next cycle new value");
    // R8 pad change while clock low
    bus_read(2'd0, 8'hAC, "R8 same cycle old value");
    #5 pad_in = 8'h35;
    bus_read(2'd0, 8'hAC, "R8 next cycle still old");
    bus_read(2'd0, 8'h3C, "R8 second cycle new value");
    // R2 unmapped and read-only addresses
    bus_read(2'd3, 8'h00, "R2 unmapped reads zero");
    bus_write(2'd3, 8'hFF);
    bus_write(2'd0, 8'hFF);
    bus_read(2'd1, 8'h0F, "R2 dir untouched by ignored writes");
    bus_read(2'd2, 8'hCC, "R2 out untouched by ignored writes");
    bus_idle(1);
    pad_check("R2 pads untouched", 8'h0F, 8'hCC, 8'hC0);
    // R5 all outputs: pads ignored
    bus_write(2'd1, 8'hFF);
    bus_idle(1);
    pad_in = 8'h00;
    bus_read(2'd0, 8'hCC, "R5 all outputs read own level");
    bus_idle(1);
    pad_check("R4 R3 all outputs no pullup", 8'hFF, 8'hCC, 8'h00);
    // R4 all inputs: pull-ups follow output register
    bus_write(2'd1, 8'h00);
    bus_write(2'd2, 8'h96);
    bus_idle(1);
    pad_check("R4 all inputs pullups", 8'h00, 8'h96, 8'h96);
    bus_idle(2);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule